// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block turns I/O-port traffic into configuration-space requests. Software first loads a 32-bit pointer register through a dword write to the pointer port. The pointer holds an enable flag, a bus number, a device/function index and a dword-aligned register index. Software then reads or writes one to four bytes through a four-byte data window. The bridge checks whether the pointer allows forwarding. If it does, it builds the register byte offset from the pointer and the low bits of the data-window address. It then raises a one-cycle read or write strobe with that offset and the access length towards a target-lookup interface.

The lookup side always sees the bus and device/function fields of the pointer. It answers in the same cycle with a present flag and, for reads, the register data. Read data reaches the I/O side in the same cycle, cut to the access length. Every access that cannot be forwarded is dropped: a write has no effect, and a read returns zero.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the pointer register is zero. A dword read of the pointer port returns 0, and no data-window access raises a strobe until the pointer is loaded.
- R2: A dword (size code 2'b10) write to the pointer port (I/O 0x0CF8) loads all 32 bits, and a dword read of that port returns them. Any other size on that port, and any access at 0x0CF9 to 0x0CFB, leaves the pointer unchanged and reads as 0.
- R3: `cfg_bus` always equals pointer bits [23:16], and `cfg_devfn` always equals pointer bits [15:8].
- R4: The forwarded offset is pointer bits [7:2] followed by the two low bits of the data-window address (0x0CFC to 0x0CFF).
- R5: When pointer bit 31 is clear, a data-window write raises no strobe and a read returns 0.
- R6: When pointer bits [1:0] are not both zero, a data-window write raises no strobe and a read returns 0.
- R7: When `cfg_present` is low for the addressed bus and device/function, no strobe is raised and a read returns 0.
- R8: A forwarded write raises `cfg_wr` for exactly the access cycle, with `cfg_wdata` equal to the I/O write data and `cfg_size` equal to the I/O size code. A forwarded read raises `cfg_rd` and returns the data in the same cycle.
- R9: Size codes are 2'b00 byte, 2'b01 word, 2'b10 dword. Read data is zero above bit 7 for a byte and above bit 15 for a word. Code 2'b11 is never forwarded and reads as 0.
- R10: An access to an I/O address outside 0x0CF8 to 0x0CFF raises no strobe, reads as 0 and leaves the pointer unchanged.
- R11: `cfg_rd` and `cfg_wr` are never high together, and neither is high without `io_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O byte address |
| io_size | input | 2 | Access length code |
| io_wdata | input | 32 | I/O write data, LSB aligned |
| io_rdata | output | 32 | I/O read data, same cycle |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_bus | output | 8 | Bus number from the pointer |
| cfg_devfn | output | 8 | Device/function index from the pointer |
| cfg_offset | output | 8 | Register byte offset |
| cfg_size | output | 2 | Length code of the request |
| cfg_wdata | output | 32 | Write data of the request |
| cfg_present | input | 1 | Target exists at cfg_bus/cfg_devfn |
| cfg_rdata | input | 32 | Target read data |

## Verification
The pointer update and the routing of a data access can meet on a single clock edge. The bench issues a pointer write and a data-window access in back-to-back cycles, and its reference model applies the new pointer only from the following cycle. A wrong pointer load or a stale route therefore appears at once as a wrong offset, a wrong strobe or wrong read data. Random streams interleave pointer writes with enable, alignment and presence variations and data accesses of every size. Each cycle is judged against a bench model of the pointer and a fixed target map.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic       en;
    logic [6:0] spare;
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [5:0] reg_dw;
    logic [1:0] low;
  } cfg_ptr_t;

  // byte lanes that survive for a given length code
  function automatic logic [LANES-1:0] lane_keep(input logic [1:0] sz);
    logic [LANES-1:0] k;
    k = '0;
    case (sz)
      SZ_BYTE:  k[0]   = 1'b1;
      SZ_WORD:  k[1:0] = 2'b11;
      SZ_DWORD: k      = '1;
      default:  k      = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_bridge_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] PTR_PORT  = 16'h0CF8,
  parameter logic [IO_AW-1:0] WIN_PORT  = 16'h0CFC
) (
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  output logic             ptr_wr,
  output logic             ptr_rd,
  output logic             win_acc,
  output logic [1:0]       win_lo
);

  localparam int            WORD_W   = IO_AW - 2;
  localparam logic [WORD_W-1:0] PTR_WORD = PTR_PORT[IO_AW-1:2];
  localparam logic [WORD_W-1:0] WIN_WORD = WIN_PORT[IO_AW-1:2];

  logic ptr_hit;

  always_comb begin
    ptr_hit = io_valid && (io_addr[IO_AW-1:2] == PTR_WORD) &&
              (io_addr[1:0] == 2'b00) && (io_size == SZ_DWORD);
    ptr_wr  = ptr_hit && io_write;
    ptr_rd  = ptr_hit && !io_write;
    win_acc = io_valid && (io_addr[IO_AW-1:2] == WIN_WORD) &&
              (io_size != SZ_RSVD);
    win_lo  = io_addr[1:0];
  end

endmodule

// File: rtl/cfg_ptr_reg.sv
module cfg_ptr_reg
  import cfg_bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic [DATA_W-1:0] wdata,
  output cfg_ptr_t ptr_q
);

  cfg_ptr_t ptr_d;

  always_comb begin
    ptr_d = cfg_ptr_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_bridge_pkg::*;
(
  input  logic              win_acc,
  input  logic              io_write,
  input  logic [1:0]        win_lo,
  input  logic [1:0]        io_size,
  input  logic              ptr_en,
  input  logic [1:0]        ptr_low,
  input  logic [5:0]        ptr_reg,
  input  logic              cfg_present,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rd,
  output logic              cfg_wr,
  output logic [7:0]        cfg_offset,
  output logic [DATA_W-1:0] fwd_rdata
);

  logic             allow;
  logic [LANES-1:0] keep;

  always_comb begin
    allow      = win_acc && ptr_en && (ptr_low == 2'b00) && cfg_present;
    cfg_rd     = allow && !io_write;
    cfg_wr     = allow && io_write;
    cfg_offset = {ptr_reg, win_lo};
    keep       = lane_keep(io_size);
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign fwd_rdata[b*8 +: 8] = (cfg_rd && keep[b]) ? cfg_rdata[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int               IO_AW    = 16,
  parameter logic [IO_AW-1:0] PTR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] WIN_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             cfg_rd,
  output logic             cfg_wr,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [7:0]       cfg_offset,
  output logic [1:0]       cfg_size,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_present,
  input  logic [31:0]      cfg_rdata
);

  logic        ptr_wr;
  logic        ptr_rd;
  logic        win_acc;
  logic [1:0]  win_lo;
  cfg_ptr_t    ptr_q;
  logic [31:0] addr_q;
  logic [31:0] fwd_rdata;

  cfg_port_decode #(
    .IO_AW   (IO_AW),
    .PTR_PORT(PTR_PORT),
    .WIN_PORT(WIN_PORT)
  ) i_decode (
    .io_valid(io_valid),
    .io_write(io_write),
    .io_addr (io_addr),
    .io_size (io_size),
    .ptr_wr  (ptr_wr),
    .ptr_rd  (ptr_rd),
    .win_acc (win_acc),
    .win_lo  (win_lo)
  );

  cfg_ptr_reg i_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ptr_wr),
    .wdata(io_wdata),
    .ptr_q(ptr_q)
  );

  cfg_route i_route (
    .win_acc    (win_acc),
    .io_write   (io_write),
    .win_lo     (win_lo),
    .io_size    (io_size),
    .ptr_en     (ptr_q.en),
    .ptr_low    (ptr_q.low),
    .ptr_reg    (ptr_q.reg_dw),
    .cfg_present(cfg_present),
    .cfg_rdata  (cfg_rdata),
    .cfg_rd     (cfg_rd),
    .cfg_wr     (cfg_wr),
    .cfg_offset (cfg_offset),
    .fwd_rdata  (fwd_rdata)
  );

  always_comb begin
    addr_q    = ptr_q;
    cfg_bus   = ptr_q.bus;
    cfg_devfn = ptr_q.devfn;
    cfg_size  = io_size;
    cfg_wdata = io_wdata;
    io_rdata  = ptr_rd ? addr_q : fwd_rdata;
  end

endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int               IO_AW    = 16,
  parameter logic [IO_AW-1:0] PTR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] WIN_PORT = 16'h0CFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_valid,
  input logic             io_write,
  input logic [IO_AW-1:0] io_addr,
  input logic [1:0]       io_size,
  input logic [31:0]      io_wdata,
  input logic [31:0]      io_rdata,
  input logic             cfg_rd,
  input logic             cfg_wr,
  input logic             cfg_present,
  input logic [31:0]      addr_q
);

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> addr_q == 32'h0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && io_addr == PTR_PORT && io_size == 2'b10)
    |=> addr_q == $past(io_wdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && io_write) |=> $stable(addr_q));

  p_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> addr_q[31]);

  p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> addr_q[1:0] == 2'b00);

  p_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> cfg_present);

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && !cfg_rd && io_addr[IO_AW-1:2] == WIN_PORT[IO_AW-1:2])
    |-> io_rdata == 32'h0);

  p_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_size == 2'b00) |-> io_rdata[31:8] == 24'h0);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd && cfg_wr));

  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> io_valid);

endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
  .IO_AW   (IO_AW),
  .PTR_PORT(PTR_PORT),
  .WIN_PORT(WIN_PORT)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_valid   (io_valid),
  .io_write   (io_write),
  .io_addr    (io_addr),
  .io_size    (io_size),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .cfg_rd     (cfg_rd),
  .cfg_wr     (cfg_wr),
  .cfg_present(cfg_present),
  .addr_q     (addr_q)
);

// File: tb/test_cfg_port_bridge.sv
`timescale 1ns/1ps
module test_cfg_port_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_valid, io_write;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata, io_rdata;
  logic        cfg_rd, cfg_wr, cfg_present;
  logic [7:0]  cfg_bus, cfg_devfn, cfg_offset;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] m_ptr;

  always #2 clk = ~clk;

  cfg_port_bridge i_cfg_port_bridge (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_offset(cfg_offset), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_present(cfg_present), .cfg_rdata(cfg_rdata)
  );

  function automatic logic dev_here(logic [7:0] b, logic [7:0] d);
    return (b < 8'd2 && d[7:3] < 5'd4) || (b == 8'd5 && d == 8'h30);
  endfunction

  function automatic logic [31:0] tgt_data(logic [7:0] b, logic [7:0] d, logic [7:0] o);
    return {b, d, o, 8'h5A};
  endfunction

  function automatic logic [31:0] cut(logic [31:0] v, logic [1:0] sz);
    case (sz)
      2'b00:   return {24'h0, v[7:0]};
      2'b01:   return {16'h0, v[15:0]};
      2'b10:   return v;
      default: return 32'h0;
    endcase
  endfunction

  // target lookup model
  assign cfg_present = dev_here(cfg_bus, cfg_devfn);
  assign cfg_rdata   = tgt_data(cfg_bus, cfg_devfn, cfg_offset);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic acc(string req, logic v, logic w, logic [15:0] a,
                     logic [1:0] sz, logic [31:0] wd);
    logic ptr_w, ptr_r, win, ok, e_rd, e_wr;
    logic [7:0]  e_off;
    logic [31:0] e_rdata;
    @(negedge clk);
    io_valid = v; io_write = w; io_addr = a; io_size = sz; io_wdata = wd;
    #1;
    ptr_w = v && w && a == 16'h0CF8 && sz == 2'b10;
    ptr_r = v && !w && a == 16'h0CF8 && sz == 2'b10;
    win   = v && a[15:2] == 14'h033F;
    ok    = m_ptr[31] && m_ptr[1:0] == 2'b00 && sz != 2'b11 &&
            dev_here(m_ptr[23:16], m_ptr[15:8]);
    e_rd  = win && !w && ok;
    e_wr  = win && w && ok;
    e_off = {m_ptr[7:2], a[1:0]};
    e_rdata = ptr_r ? m_ptr :
              e_rd  ? cut(tgt_data(m_ptr[23:16], m_ptr[15:8], e_off), sz) : 32'h0;
    chk(req, "cfg_rd", {31'h0, cfg_rd}, {31'h0, e_rd});
    chk(req, "cfg_wr", {31'h0, cfg_wr}, {31'h0, e_wr});
    chk(req, "io_rdata", io_rdata, e_rdata);
    chk("R3", "bus/devfn", {16'h0, cfg_bus, cfg_devfn}, {16'h0, m_ptr[23:8]});
    if (e_rd || e_wr) begin
      chk("R4", "offset", {24'h0, cfg_offset}, {24'h0, e_off});
      chk("R8", "size", {30'h0, cfg_size}, {30'h0, sz});
    end
    if (e_wr) chk("R8", "wdata", cfg_wdata, wd);
    if (ptr_w) m_ptr = wd;
  endtask

  function automatic logic [31:0] mk_ptr(logic en, logic [7:0] b, logic [7:0] d,
                                         logic [5:0] r, logic [1:0] lo);
    return {en, 7'h0, b, d, r, lo};
  endfunction

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ptr = 32'h0;
    rst_n = 1'b0; io_valid = 0; io_write = 0; io_addr = 0; io_size = 0; io_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    acc("R1", 1, 0, 16'h0CF8, 2'b10, 0);
    acc("R1", 1, 0, 16'h0CFC, 2'b10, 0);
    acc("R1", 1, 1, 16'h0CFC, 2'b10, 32'h1234_5678);

    // R2: load and read back, then immediate data access (back-to-back)
    acc("R2", 1, 1, 16'h0CF8, 2'b10, mk_ptr(1, 8'd0, 8'h08, 6'h01, 2'b00));
    acc("R2", 1, 0, 16'h0CF8, 2'b10, 0);
    acc("R4", 1, 0, 16'h0CFD, 2'b00, 0);   // byte, offset 0x05
    acc("R9", 1, 0, 16'h0CFE, 2'b01, 0);   // word
    acc("R8", 1, 0, 16'h0CFC, 2'b10, 0);   // dword
    acc("R8", 1, 1, 16'h0CFF, 2'b00, 32'hDEAD_BEEF);
    acc("R9", 1, 0, 16'h0CFC, 2'b11, 0);   // reserved size
    acc("R9", 1, 1, 16'h0CFC, 2'b11, 32'h1);

    // R2: non-dword or misaligned pointer-port accesses ignored
    acc("R2", 1, 1, 16'h0CF8, 2'b00, 32'hFFFF_FFFF);
    acc("R2", 1, 1, 16'h0CF9, 2'b10, 32'hFFFF_FFFF);
    acc("R2", 1, 0, 16'h0CF8, 2'b01, 0);
    acc("R2", 1, 0, 16'h0CF8, 2'b10, 0);

    // R5: enable clear
    acc("R5", 1, 1, 16'h0CF8, 2'b10, mk_ptr(0, 8'd0, 8'h08, 6'h01, 2'b00));
    acc("R5", 1, 0, 16'h0CFC, 2'b10, 0);
    acc("R5", 1, 1, 16'h0CFC, 2'b10, 32'h5);

    // R6: low pointer bits set
    acc("R6", 1, 1, 16'h0CF8, 2'b10, mk_ptr(1, 8'd1, 8'h10, 6'h3F, 2'b01));
    acc("R6", 1, 0, 16'h0CFC, 2'b10, 0);
    acc("R6", 1, 1, 16'h0CFD, 2'b00, 32'h7);

    // R7: absent device, then a present one at a far offset
    acc("R7", 1, 1, 16'h0CF8, 2'b10, mk_ptr(1, 8'd3, 8'h00, 6'h02, 2'b00));
    acc("R7", 1, 0, 16'h0CFC, 2'b10, 0);
    acc("R7", 1, 1, 16'h0CFC, 2'b10, 32'h9);
    acc("R4", 1, 1, 16'h0CF8, 2'b10, mk_ptr(1, 8'd5, 8'h30, 6'h3F, 2'b00));
    acc("R4", 1, 0, 16'h0CFF, 2'b00, 0);   // offset 0xFF

    // R10: outside both ports
    acc("R10", 1, 1, 16'h0080, 2'b10, 32'h0);
    acc("R10", 1, 0, 16'h0CF4, 2'b10, 0);
    acc("R10", 1, 0, 16'h0D00, 2'b10, 0);
    acc("R11", 0, 1, 16'h0CFC, 2'b10, 32'h3);  // idle, no strobe

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [1:0] lo, sz;
      op = $urandom % 10;
      lo = 2'($urandom);
      sz = 2'($urandom);
      if (op < 2) begin
        acc("R2", 1, 1, 16'h0CF8, 2'b10,
            mk_ptr(($urandom % 4) != 0, 8'($urandom % 7), 8'($urandom % 48),
                   6'($urandom), (($urandom % 5) == 0) ? 2'($urandom) : 2'b00));
      end else if (op == 2) begin
        acc("R2", 1, 0, 16'h0CF8, 2'b10, 0);
      end else if (op < 6) begin
        acc("R8", 1, 0, {14'h033F, lo}, sz, 0);
      end else if (op < 8) begin
        acc("R8", 1, 1, {14'h033F, lo}, sz, $urandom);
      end else if (op == 8) begin
        acc("R2", 1, 1'($urandom), {14'h033E, lo}, sz, $urandom);
      end else begin
        acc("R10", 1, 1'($urandom), 16'($urandom), sz, $urandom);
      end
    end

    @(negedge clk) io_valid = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule